// File: doc/BRIEF.md
# Fractional Audio Bit-Clock Divider

This block derives an audio bit clock from one of several reference sources. Each source arrives as a one-cycle tick on the system clock, so the divider counts source cycles without a second clock domain. The divisor has an integer part and a 12-bit fraction. In integer mode the output period is the integer part alone. In first-order noise-shaped mode a phase accumulator sums the fraction once per output period, and each carry out of it lengthens that period by one source cycle. The mean frequency then comes close to source / (I + F/4096).

Software drives two 32-bit words through a simple write/read port: a control word and a divisor word. A write only lands when its top byte carries the key value. Setting the run bit starts the generator. Clearing it lets the current output period finish, and busy then drops with the output parked low. The stop bit halts and clears the generator at once. While busy is high the generator keeps its own frozen copy of divisor, mode and source, so the registers can be rewritten without disturbing the running waveform.

Top module: `frac_clk_div`

## Requirements
- R1: A write to either word (`wr_sel` 0 = control, 1 = divisor) is accepted only when `wr_data[31:24]` equals 0x5A; any other write leaves both words unchanged.
- R2: Control word read-back: mode in bits 10:9, busy in bit 7, stop in bit 5, run in bit 4, source in bits 3:0, all other bits zero. Busy is read-only and writes to bit 7 are ignored. Divisor word read-back: integer part in bits 12 and up, fraction in bits 11:0, all other bits zero. The key byte reads as zero.
- R3: With mode 0 every output period lasts N = max(I, 2) source cycles, the output is high for the first floor(N/2) of them, and the fraction has no effect.
- R4: With a nonzero mode (values 2 and 3 act as 1), each period adds F to a 12-bit accumulator that starts at zero. The period lasts max(I, 2) + c source cycles, where c is the carry of that addition.
- R5: Setting run while idle raises busy on the next cycle. The output stays low until the first tick of the selected source, which starts the first period.
- R6: Clearing run does not cut the current period: busy falls exactly at the end of the period in progress, and the output is then low.
- R7: Setting stop drops busy and the output on the next cycle whatever the state, and no start takes place while stop stays set.
- R8: Source 0, and any source number at or above the number of sources, is ground: no tick reaches the generator and the output does not toggle.
- R9: The generator captures divisor, mode and source only while busy is low; words written during a run take effect at the next start.
- R10: Period lengths are counted in ticks of the selected source, so a source ticking every third system cycle gives periods of 3N system cycles.
- R11: After reset both words read zero, busy is low and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NUM_SRC | One-cycle tick per reference source cycle, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 divisor word |
| wr_data | input | 32 | Write data including key byte |
| rd_sel | input | 1 | Read select: 0 control word, 1 divisor word |
| rd_data | output | 32 | Combinational read data |
| clk_out | output | 1 | Divided bit clock |
| busy | output | 1 | Generator running |

## Verification
The embedded properties check these rules on every cycle: the key gating of writes, the immediate effect of stop, busy falling only at a period boundary, the period counter staying within the current length, the output low while idle, a ground source never ticking, and the frozen configuration while running. Only the bench scenarios can show the period and high-time figures. The bench sweeps integer divisors including those below 2, and fractions across the range in both modes. It also covers period scaling by a slower source, stop timing measured from the last rising edge, and deferred divisor changes.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int          FRAC_W   = 12;
  localparam int          KEY_LSB  = 24;
  localparam logic [7:0]  KEY_BYTE = 8'h5A;
  localparam int          MODE_LSB = 9;
  localparam int          BUSY_BIT = 7;
  localparam int          STOP_BIT = 5;
  localparam int          RUN_BIT  = 4;
  localparam int          SRC_W    = 4;
  localparam int          INT_LSB  = 12;

  typedef enum logic [1:0] {
    MODE_INT  = 2'd0,
    MODE_ORD1 = 2'd1,
    MODE_RSV2 = 2'd2,
    MODE_RSV3 = 2'd3
  } shape_mode_e;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int INT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_sel,
  input  logic [31:0]             wr_data,
  input  logic                    rd_sel,
  input  logic                    busy,
  output logic [31:0]             rd_data,
  output shape_mode_e             mode,
  output logic                    stop,
  output logic                    run,
  output logic [SRC_W-1:0]        src,
  output logic [INT_W-1:0]        int_div,
  output logic [FRAC_W-1:0]       frac_div
);
  localparam int INT_MSB = INT_LSB + INT_W - 1;

  shape_mode_e       mode_q, mode_d;
  logic              stop_q, stop_d, run_q, run_d;
  logic [SRC_W-1:0]  src_q, src_d;
  logic [INT_W-1:0]  int_q, int_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              key_ok;

  assign key_ok = wr_data[31:KEY_LSB] == KEY_BYTE;

  always_comb begin
    mode_d = mode_q;
    stop_d = stop_q;
    run_d  = run_q;
    src_d  = src_q;
    int_d  = int_q;
    frac_d = frac_q;
    if (wr_en && key_ok) begin
      if (!wr_sel) begin
        mode_d = shape_mode_e'(wr_data[MODE_LSB+1:MODE_LSB]);
        stop_d = wr_data[STOP_BIT];
        run_d  = wr_data[RUN_BIT];
        src_d  = wr_data[SRC_W-1:0];
      end else begin
        int_d  = wr_data[INT_MSB:INT_LSB];
        frac_d = wr_data[FRAC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INT;
      stop_q <= 1'b0;
      run_q  <= 1'b0;
      src_q  <= '0;
      int_q  <= '0;
      frac_q <= '0;
    end else begin
      mode_q <= mode_d;
      stop_q <= stop_d;
      run_q  <= run_d;
      src_q  <= src_d;
      int_q  <= int_d;
      frac_q <= frac_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (!rd_sel) begin
      rd_data[MODE_LSB+1:MODE_LSB] = mode_q;
      rd_data[BUSY_BIT]            = busy;
      rd_data[STOP_BIT]            = stop_q;
      rd_data[RUN_BIT]             = run_q;
      rd_data[SRC_W-1:0]           = src_q;
    end else begin
      rd_data[INT_MSB:INT_LSB]     = int_q;
      rd_data[FRAC_W-1:0]          = frac_q;
    end
  end

  assign mode     = mode_q;
  assign stop     = stop_q;
  assign run      = run_q;
  assign src      = src_q;
  assign int_div  = int_q;
  assign frac_div = frac_q;

  // R1: a write without the key leaves every field untouched
  a_r1_key_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[31:KEY_LSB] != KEY_BYTE)) |=>
      ($stable(mode_q) && $stable(stop_q) && $stable(run_q) &&
       $stable(src_q) && $stable(int_q) && $stable(frac_q)));
endmodule

// File: rtl/clkdiv_src_sel.sv
module clkdiv_src_sel
  import clkdiv_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SRC_W-1:0]   sel,
  output logic               tick
);
  logic [NUM_SRC-1:0] hit;
  logic               tick_d, tick_q;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
      if (i == 0) begin : g_gnd
        assign hit[i] = 1'b0;
      end else begin : g_live
        assign hit[i] = src_tick[i] && (sel == SRC_W'(i));
      end
    end
  endgenerate

  assign tick_d = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign tick = tick_q;

  // R8: a grounded selection never yields a tick
  a_r8_ground_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> !tick_q);
endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen
  import clkdiv_pkg::*;
#(
  parameter int INT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              stop,
  input  shape_mode_e       mode,
  input  logic [INT_W-1:0]  int_div,
  input  logic [FRAC_W-1:0] frac_div,
  output logic              clk_out,
  output logic              busy
);
  localparam int CNT_W = INT_W + 1;

  logic              busy_q, busy_d, lvl_q, lvl_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, len_q, len_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0]  base, next_len, cnt_inc, half;
  logic [FRAC_W:0]   sum;
  logic              carry, at_end;

  assign base     = (int_div < INT_W'(2)) ? CNT_W'(2) : {1'b0, int_div};
  assign sum      = {1'b0, acc_q} + {1'b0, (mode == MODE_INT) ? '0 : frac_div};
  assign carry    = sum[FRAC_W];
  assign next_len = base + {{(CNT_W-1){1'b0}}, carry};
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign half     = len_q >> 1;
  assign at_end   = cnt_q == (len_q - CNT_W'(1));

  always_comb begin
    busy_d = busy_q;
    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    acc_d  = acc_q;
    if (stop) begin
      busy_d = 1'b0;
      lvl_d  = 1'b0;
      cnt_d  = '0;
      len_d  = CNT_W'(2);
      acc_d  = '0;
    end else if (!busy_q) begin
      if (run) begin
        busy_d = 1'b1;
        lvl_d  = 1'b0;
        len_d  = CNT_W'(2);
        cnt_d  = CNT_W'(1);
        acc_d  = '0;
      end
    end else if (tick) begin
      if (at_end) begin
        if (run) begin
          lvl_d = 1'b1;
          cnt_d = '0;
          len_d = next_len;
          acc_d = sum[FRAC_W-1:0];
        end else begin
          busy_d = 1'b0;
          lvl_d  = 1'b0;
          cnt_d  = '0;
          len_d  = CNT_W'(2);
          acc_d  = '0;
        end
      end else begin
        cnt_d = cnt_inc;
        lvl_d = cnt_inc < half;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= CNT_W'(2);
      acc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      acc_q  <= acc_d;
    end
  end

  assign clk_out = lvl_q;
  assign busy    = busy_q;

  // R7: stop halts the generator on the next edge
  a_r7_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy_q && !lvl_q));

  // R6: without stop, busy only falls once the final count of a period is reached
  a_r6_clean_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !$past(stop)) |-> ($past(cnt_q) == $past(len_q) - CNT_W'(1)));

  // R3: the period counter stays inside the current period length
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < len_q));

  // R5: the output rests low while idle
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !lvl_q);
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import clkdiv_pkg::*;
#(
  parameter int INT_W   = 12,
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [31:0]        wr_data,
  input  logic               rd_sel,
  output logic [31:0]        rd_data,
  output logic               clk_out,
  output logic               busy
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  shape_mode_e       r_mode, c_mode_q, c_mode_d;
  logic              r_stop, r_run;
  logic [SRC_W-1:0]  r_src, c_src_q, c_src_d;
  logic [INT_W-1:0]  r_int, c_int_q, c_int_d;
  logic [FRAC_W-1:0] r_frac, c_frac_q, c_frac_d;
  logic              sel_tick, gen_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  clkdiv_regs #(.INT_W(INT_W)) regs_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .busy(gen_busy), .rd_data(rd_data),
    .mode(r_mode), .stop(r_stop), .run(r_run), .src(r_src),
    .int_div(r_int), .frac_div(r_frac)
  );

  always_comb begin
    c_mode_d = c_mode_q;
    c_src_d  = c_src_q;
    c_int_d  = c_int_q;
    c_frac_d = c_frac_q;
    if (!gen_busy) begin
      c_mode_d = r_mode;
      c_src_d  = r_src;
      c_int_d  = r_int;
      c_frac_d = r_frac;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      c_mode_q <= MODE_INT;
      c_src_q  <= '0;
      c_int_q  <= '0;
      c_frac_q <= '0;
    end else begin
      c_mode_q <= c_mode_d;
      c_src_q  <= c_src_d;
      c_int_q  <= c_int_d;
      c_frac_q <= c_frac_d;
    end
  end

  clkdiv_src_sel #(.NUM_SRC(NUM_SRC)) sel_i (
    .clk(clk), .rst_n(rst_int_n), .src_tick(src_tick), .sel(c_src_q),
    .tick(sel_tick)
  );

  clkdiv_gen #(.INT_W(INT_W)) gen_i (
    .clk(clk), .rst_n(rst_int_n), .tick(sel_tick), .run(r_run), .stop(r_stop),
    .mode(c_mode_q), .int_div(c_int_q), .frac_div(c_frac_q),
    .clk_out(clk_out), .busy(gen_busy)
  );

  assign busy = gen_busy;

  // R9: the captured configuration holds still across a run
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_int_n)
    (gen_busy && $past(gen_busy)) |->
      ($stable(c_int_q) && $stable(c_frac_q) && $stable(c_mode_q) && $stable(c_src_q)));
endmodule

// File: tb/frac_clk_div_tb_top.sv
module frac_clk_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_tick = 8'h00;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clk_out, busy;

  int n_tot = 0, n_bad = 0, cyc = 0;
  int rise_t[0:63];
  int hi_of[0:63];
  int n_rise = 0, hi_acc = 0, fall_t = -1;
  logic prev_o = 1'b0, prev_b = 1'b0;

  frac_clk_div #(.INT_W(12), .NUM_SRC(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .clk_out(clk_out), .busy(busy)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // source 1 ticks every cycle, source 2 every third, source 7 every cycle
  always @(negedge clk) begin
    src_tick[1] = 1'b1;
    src_tick[2] = (cyc % 3) == 0;
    src_tick[7] = 1'b1;
  end

  always @(negedge clk) begin
    if (clk_out && !prev_o) begin
      if (n_rise > 0 && n_rise < 64) hi_of[n_rise-1] = hi_acc;
      if (n_rise < 64) rise_t[n_rise] = cyc;
      n_rise = n_rise + 1;
      hi_acc = 1;
    end else if (clk_out) begin
      hi_acc = hi_acc + 1;
    end
    if (prev_b && !busy) fall_t = cyc;
    prev_o = clk_out;
    prev_b = busy;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tot = n_tot + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input int m, input bit k, input bit r, input int s);
    logic [31:0] w;
    w = '0;
    w[31:24] = 8'h5A;
    w[10:9]  = 2'(m);
    w[5]     = k;
    w[4]     = r;
    w[3:0]   = 4'(s);
    return w;
  endfunction

  function automatic logic [31:0] dw(input int i, input int f);
    return {8'h5A, 12'(i), 12'(f)};
  endfunction

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input bit sel, output logic [31:0] d);
    @(negedge clk);
    rd_sel = sel;
    #1 d = rd_data;
  endtask

  task automatic clear_mon();
    @(negedge clk);
    n_rise = 0; hi_acc = 0; fall_t = -1;
  endtask

  task automatic wait_rises(input int k);
    for (int lim = 0; lim < 20000 && n_rise < k; lim++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int lim = 0; lim < 20000 && busy; lim++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int n, per, acc, c, ex;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 clk_out", clk_out, 0);
    rd(1'b0, v); chk("R11 ctrl word", v, 0);
    rd(1'b1, v); chk("R11 divisor word", v, 0);

    // R1 key gating
    wr(1'b1, {8'h5B, 12'd7, 12'd9});
    rd(1'b1, v); chk("R1 bad key divisor", v, 0);
    wr(1'b0, {8'hA5, 24'h000617});
    rd(1'b0, v); chk("R1 bad key ctrl", v, 0);
    wr(1'b1, dw(7, 9));
    rd(1'b1, v); chk("R1 good key divisor", v, {8'h00, 12'd7, 12'd9});

    // R2 layout, busy bit read-only, stray bits read zero
    wr(1'b0, cw(3, 1'b1, 1'b0, 6) | 32'h00FF_F9C0);
    rd(1'b0, v); chk("R2 ctrl readback", v, 32'h0000_0626);
    wr(1'b0, cw(0, 1'b0, 1'b0, 1));

    // R3 integer sweep, fraction ignored
    for (int d = 0; d < 10; d++) begin
      n = (d < 2) ? 2 : d;
      wr(1'b1, dw(d, 12'hA55));
      wr(1'b0, cw(0, 1'b0, 1'b0, 1));
      clear_mon();
      wr(1'b0, cw(0, 1'b0, 1'b1, 1));
      chk("R5 busy after start", busy, 1);
      wait_rises(6);
      for (int j = 0; j < 4; j++) begin
        chk($sformatf("R3 period d=%0d j=%0d", d, j), rise_t[j+1] - rise_t[j], n);
        chk($sformatf("R3 high d=%0d j=%0d", d, j), hi_of[j], n / 2);
      end
      rd(1'b0, v); chk("R2 busy bit while running", v[7], 1);
      wr(1'b0, cw(0, 1'b0, 1'b0, 1));
      wait_idle();
      chk($sformatf("R6 stop at period end d=%0d", d),
          fall_t - rise_t[(n_rise > 64 ? 64 : n_rise) - 1], n);
      chk("R6 output low after stop", clk_out, 0);
    end

    // R4 first-order sweep
    for (int d = 2; d < 6; d += 3) begin
      for (int fi = 0; fi < 6; fi++) begin
        int fr;
        int md;
        case (fi)
          0: fr = 12'h001; 1: fr = 12'h400; 2: fr = 12'h800;
          3: fr = 12'hC00; 4: fr = 12'hFFF; default: fr = 12'h555;
        endcase
        md = (fi == 5) ? 3 : 1;
        wr(1'b1, dw(d, fr));
        wr(1'b0, cw(md, 1'b0, 1'b0, 1));
        clear_mon();
        wr(1'b0, cw(md, 1'b0, 1'b1, 1));
        wait_rises(14);
        acc = 0;
        for (int j = 0; j < 12; j++) begin
          acc = acc + fr;
          c = (acc >= 4096) ? 1 : 0;
          acc = acc % 4096;
          ex = d + c;
          chk($sformatf("R4 period d=%0d f=%0d j=%0d", d, fr, j),
              rise_t[j+1] - rise_t[j], ex);
        end
        wr(1'b0, cw(md, 1'b0, 1'b0, 1));
        wait_idle();
      end
    end

    // R10 slower source: periods scale by three
    wr(1'b1, dw(4, 0));
    wr(1'b0, cw(0, 1'b0, 1'b0, 2));
    clear_mon();
    wr(1'b0, cw(0, 1'b0, 1'b1, 2));
    wait_rises(5);
    for (int j = 0; j < 3; j++)
      chk("R10 period on source 2", rise_t[j+1] - rise_t[j], 12);
    wr(1'b0, cw(0, 1'b0, 1'b0, 2));
    wait_idle();

    // R8 ground source 0 and out-of-range source 9
    for (int s = 0; s < 10; s += 9) begin
      wr(1'b0, cw(0, 1'b0, 1'b0, s));
      clear_mon();
      wr(1'b0, cw(0, 1'b0, 1'b1, s));
      repeat (100) @(negedge clk);
      chk($sformatf("R8 no toggles src=%0d", s), n_rise, 0);
      chk("R8 output low", clk_out, 0);
      wr(1'b0, cw(0, 1'b1, 1'b1, s));
      wr(1'b0, cw(0, 1'b0, 1'b0, s));
    end

    // R7 stop mid-run, no restart while stop held
    wr(1'b1, dw(20, 0));
    wr(1'b0, cw(0, 1'b0, 1'b0, 7));
    wr(1'b0, cw(0, 1'b0, 1'b1, 7));
    repeat (5) @(negedge clk);
    chk("R7 running before stop", busy, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = cw(0, 1'b1, 1'b1, 7);
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    chk("R7 busy dropped next cycle", busy, 0);
    chk("R7 output low", clk_out, 0);
    repeat (30) @(negedge clk);
    chk("R7 no restart while stop", busy, 0);
    wr(1'b0, cw(0, 1'b0, 1'b0, 7));

    // R9 divisor rewrite during a run is deferred
    wr(1'b1, dw(4, 0));
    wr(1'b0, cw(0, 1'b0, 1'b0, 1));
    wr(1'b0, cw(0, 1'b0, 1'b1, 1));
    wr(1'b1, dw(6, 0));
    clear_mon();
    wait_rises(4);
    for (int j = 0; j < 3; j++)
      chk("R9 old period kept", rise_t[j+1] - rise_t[j], 4);
    rd(1'b1, v); chk("R9 word accepted", v, {8'h00, 12'd6, 12'd0});
    wr(1'b0, cw(0, 1'b0, 1'b0, 1));
    wait_idle();
    clear_mon();
    wr(1'b0, cw(0, 1'b0, 1'b1, 1));
    wait_rises(4);
    for (int j = 0; j < 3; j++)
      chk("R9 new period after restart", rise_t[j+1] - rise_t[j], 6);
    wr(1'b0, cw(0, 1'b0, 1'b0, 1));
    wait_idle();

    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule